// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block performs the processor's side of taking an interrupt. Peripheral request lines arrive already qualified by their own local enables. A global mask input gates them all. When at least one line is pending and the mask is clear, the sequencer arms and waits for the instruction-boundary strobe. At that boundary it captures the program counter, index register, accumulator and condition-code byte. It also latches the number of the winning source.

It then writes five bytes to the stack through a byte-wide memory port, moving its own stack pointer down by one after each byte. Next it pulses a request to set the global mask. It reads a big-endian 16-bit service address from the vector slot of the latched source and presents that address as the new program counter, together with a one-cycle done pulse. Vector slots are two bytes each. The slot for source `i` starts at `VEC_TOP - 2*(i+1)`, so a higher source number has a lower slot address and wins arbitration.

The controller uses eleven named states:
- `ST_IDLE`: goes to `ST_ARMED` when a request is pending and the mask is clear.
- `ST_ARMED`: returns to `ST_IDLE` if that condition lapses, or goes to `ST_PUSH_PCL` on the boundary strobe.
- Push chain: `ST_PUSH_PCL` → `ST_PUSH_PCH` → `ST_PUSH_X` → `ST_PUSH_A` → `ST_PUSH_CCR`.
- Vector fetch: `ST_VEC_HI` (mask set, high-byte read) → `ST_VEC_LO` (low-byte read) → `ST_VEC_CAP` (low byte captured).
- `ST_DONE` (done pulse) → `ST_IDLE`.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we`, `mem_re` and `imask_set` are 0 and `sp` equals `SP_RESET`.
- R2: While `imask` is 1, no entry starts, whatever the request lines and boundary strobe do.
- R3: Entry does not start before a boundary strobe. The first stack write appears in the cycle after the clock edge that samples `insn_end` high in the armed state.
- R4: Stack writes take five consecutive cycles carrying, in order, PC bits 7:0, PC bits 15:8, X, A, then the condition-code byte. All values are those present at the boundary edge.
- R5: Each write goes to the current `sp`, and `sp` drops by exactly 1 after each written byte and holds otherwise. It is not restored between entries.
- R6: `imask_set` is high for exactly one cycle, the cycle right after the condition-code write.
- R7: The source used is the highest-numbered request line that was set at the boundary edge.
- R8: The high vector byte is read at `VEC_TOP - 2*(i+1)` (low 16 bits) in the `imask_set` cycle. The low byte is read at that address plus 1 in the next cycle. Read data is expected one cycle after `mem_re`.
- R9: `busy` is 1 from the first stack write through the cycle after the low-byte read. `done` is then high for one cycle with `busy` 0, and `new_pc` equals `{high byte, low byte}`.
- R10: Changes on the request lines after the boundary edge do not alter the chosen vector.
- R11: If every request line drops while armed, the block returns to idle and a later boundary strobe starts no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_SRC | Locally enabled request lines, bit i is source i |
| imask | input | 1 | Global interrupt mask, 1 blocks entry |
| insn_end | input | 1 | Instruction-boundary strobe |
| pc_in | input | 16 | Program counter to save |
| x_in | input | 8 | Index register to save |
| a_in | input | 8 | Accumulator to save |
| ccr_in | input | 8 | Condition-code byte to save |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Vector read strobe |
| mem_addr | output | ADDR_W | Memory address for write or read |
| mem_wdata | output | 8 | Byte being stacked |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| sp | output | ADDR_W | Stack pointer |
| imask_set | output | 1 | Pulse requesting the global mask be set |
| busy | output | 1 | Entry in progress |
| done | output | 1 | Entry complete, `new_pc` valid |
| new_pc | output | 16 | Service routine address |

## Verification
The boundary strobe is driven at a falling edge, and every later result is counted from the rising edge that samples it. The stack writes are due at falling edges 1 to 5 after that edge. The mask pulse and the high-byte read are due at 6, the low-byte read at 7, the capture cycle at 8, and done with the new program counter at 9. The bench samples exactly those falling edges and checks address, data and strobes there. For idle cases, masked requests and withdrawn requests, it samples every falling edge over a fixed window and expects no write. The bench sweeps every nonzero request pattern of eight sources. The expected vector, stacked bytes and stack addresses are computed arithmetically from the pattern.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int BYTE_W = 8;
    localparam int PC_W   = 2 * BYTE_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARMED,
        ST_PUSH_PCL,
        ST_PUSH_PCH,
        ST_PUSH_X,
        ST_PUSH_A,
        ST_PUSH_CCR,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_VEC_CAP,
        ST_DONE
    } entry_state_e;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [BYTE_W-1:0] x;
        logic [BYTE_W-1:0] a;
        logic [BYTE_W-1:0] ccr;
    } cpu_ctx_t;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    logic [NUM_SRC-1:0] chain_any;
    logic [IDX_W-1:0]   chain_idx [NUM_SRC];

    assign chain_any[0] = req[0];
    assign chain_idx[0] = '0;

    // Higher source number overrides lower: it owns the lower vector slot.
    generate
        for (genvar i = 1; i < NUM_SRC; i++) begin : g_stage
            assign chain_any[i] = chain_any[i-1] | req[i];
            assign chain_idx[i] = req[i] ? IDX_W'(i) : chain_idx[i-1];
        end
    endgenerate

    assign any = chain_any[NUM_SRC-1];
    assign idx = chain_idx[NUM_SRC-1];

endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
    parameter int          ADDR_W  = 16,
    parameter int          IDX_W   = 3,
    parameter int unsigned VEC_TOP = 32'h0001_0000
) (
    input  logic [IDX_W-1:0]  src,
    output logic [ADDR_W-1:0] slot
);

    logic [31:0] full_addr;

    always_comb begin
        full_addr = VEC_TOP - (32'(src) + 32'd1) * 32'd2;
        slot      = full_addr[ADDR_W-1:0];
    end

endmodule

// File: rtl/irq_stack_ptr.sv
module irq_stack_ptr #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SP_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec,
    output logic [ADDR_W-1:0] sp
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= SP_RESET;
        end else if (dec) begin
            sp <= sp - ADDR_W'(1);
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int                NUM_SRC  = 8,
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SP_RESET = 16'h01FF,
    parameter int unsigned       VEC_TOP  = 32'h0001_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               imask,
    input  logic               insn_end,
    input  logic [15:0]        pc_in,
    input  logic [7:0]         x_in,
    input  logic [7:0]         a_in,
    input  logic [7:0]         ccr_in,
    output logic               mem_we,
    output logic               mem_re,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    output logic [ADDR_W-1:0]  sp,
    output logic               imask_set,
    output logic               busy,
    output logic               done,
    output logic [15:0]        new_pc
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    entry_state_e state_q, state_d;

    logic              pend_any;
    logic [IDX_W-1:0]  pend_idx;
    logic              take;
    logic              boundary_hit;
    logic [IDX_W-1:0]  win_q;
    logic [ADDR_W-1:0] slot_addr;
    cpu_ctx_t          ctx_q;
    logic [7:0]        vec_hi_q;
    logic [15:0]       new_pc_q;

    irq_prio_pick #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_pick (
        .req (irq_req),
        .any (pend_any),
        .idx (pend_idx)
    );

    irq_vec_addr #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .VEC_TOP (VEC_TOP)
    ) u_vaddr (
        .src  (win_q),
        .slot (slot_addr)
    );

    irq_stack_ptr #(
        .ADDR_W   (ADDR_W),
        .SP_RESET (SP_RESET)
    ) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (mem_we),
        .sp    (sp)
    );

    assign take         = pend_any && !imask;
    assign boundary_hit = (state_q == ST_ARMED) && take && insn_end;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!take)         state_d = ST_IDLE;
                else if (insn_end) state_d = ST_PUSH_PCL;
            end
            ST_PUSH_PCL: state_d = ST_PUSH_PCH;
            ST_PUSH_PCH: state_d = ST_PUSH_X;
            ST_PUSH_X:   state_d = ST_PUSH_A;
            ST_PUSH_A:   state_d = ST_PUSH_CCR;
            ST_PUSH_CCR: state_d = ST_VEC_HI;
            ST_VEC_HI:   state_d = ST_VEC_LO;
            ST_VEC_LO:   state_d = ST_VEC_CAP;
            ST_VEC_CAP:  state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Context, winner and vector capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q    <= '0;
            win_q    <= '0;
            vec_hi_q <= '0;
            new_pc_q <= '0;
        end else begin
            if (boundary_hit) begin
                ctx_q.pc  <= pc_in;
                ctx_q.x   <= x_in;
                ctx_q.a   <= a_in;
                ctx_q.ccr <= ccr_in;
                win_q     <= pend_idx;
            end
            if (state_q == ST_VEC_LO) begin
                vec_hi_q <= mem_rdata;
            end
            if (state_q == ST_VEC_CAP) begin
                new_pc_q <= {vec_hi_q, mem_rdata};
            end
        end
    end

    // Output decode
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        imask_set = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ARMED: begin
            end
            ST_PUSH_PCL: begin
                busy      = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp;
                mem_wdata = ctx_q.pc[7:0];
            end
            ST_PUSH_PCH: begin
                busy      = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp;
                mem_wdata = ctx_q.pc[15:8];
            end
            ST_PUSH_X: begin
                busy      = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp;
                mem_wdata = ctx_q.x;
            end
            ST_PUSH_A: begin
                busy      = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp;
                mem_wdata = ctx_q.a;
            end
            ST_PUSH_CCR: begin
                busy      = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp;
                mem_wdata = ctx_q.ccr;
            end
            ST_VEC_HI: begin
                busy      = 1'b1;
                imask_set = 1'b1;
                mem_re    = 1'b1;
                mem_addr  = slot_addr;
            end
            ST_VEC_LO: begin
                busy     = 1'b1;
                mem_re   = 1'b1;
                mem_addr = slot_addr + ADDR_W'(1);
            end
            ST_VEC_CAP: begin
                busy = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign new_pc = new_pc_q;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              imask,
    input logic              insn_end,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] sp,
    input logic              imask_set
);

    a_r5_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp == $past(sp) - ADDR_W'(1));

    a_r5_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |=> $stable(sp));

    a_r4_write_in_entry: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    a_r6_mask_after_stack: assert property (@(posedge clk) disable iff (!rst_n)
        imask_set |-> $past(mem_we) && !mem_we && mem_re);

    a_r8_low_byte_next: assert property (@(posedge clk) disable iff (!rst_n)
        imask_set |=> mem_re && !imask_set && mem_addr == $past(mem_addr) + ADDR_W'(1));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));

    a_r2_entry_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!imask) && $past(insn_end));

endmodule

bind irq_entry_seq irq_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imask     (imask),
    .insn_end  (insn_end),
    .busy      (busy),
    .done      (done),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .sp        (sp),
    .imask_set (imask_set)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;

    localparam int          NSRC = 8;
    localparam int          AW   = 16;
    localparam logic [15:0] SP0  = 16'h01FF;
    localparam int unsigned VTOP = 32'h0001_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_req = '0;
    logic            imask = 1'b0;
    logic            insn_end = 1'b0;
    logic [15:0]     pc_in = '0;
    logic [7:0]      x_in = '0;
    logic [7:0]      a_in = '0;
    logic [7:0]      ccr_in = '0;
    logic            mem_we, mem_re, imask_set, busy, done;
    logic [AW-1:0]   mem_addr, sp;
    logic [7:0]      mem_wdata;
    logic [7:0]      mem_rdata = '0;
    logic [15:0]     new_pc;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] exp_sp;

    always #2 clk = ~clk;

    irq_entry_seq #(
        .NUM_SRC  (NSRC),
        .ADDR_W   (AW),
        .SP_RESET (SP0),
        .VEC_TOP  (VTOP)
    ) u_irq_entry_seq (
        .clk (clk), .rst_n (rst_n), .irq_req (irq_req), .imask (imask),
        .insn_end (insn_end), .pc_in (pc_in), .x_in (x_in), .a_in (a_in),
        .ccr_in (ccr_in), .mem_we (mem_we), .mem_re (mem_re),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .sp (sp), .imask_set (imask_set), .busy (busy), .done (done),
        .new_pc (new_pc)
    );

    function automatic logic [7:0] vbyte(input logic [15:0] a);
        return (a[7:0] ^ a[15:8]) + 8'h3C;
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= vbyte(mem_addr);
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic quiet_window(input string tag, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            chk(!mem_we && !busy, tag, {30'd0, mem_we, busy}, 32'd0);
        end
    endtask

    task automatic do_entry(input logic [NSRC-1:0] pat, input logic [15:0] pcv,
                            input logic [7:0] xv, input logic [7:0] av,
                            input logic [7:0] cv);
        int hi;
        logic [15:0] slot;
        logic [7:0]  bytes [5];
        logic [15:0] exp_pc;
        hi = 0;
        for (int i = 0; i < NSRC; i++) if (pat[i]) hi = i;
        slot = 16'(VTOP - 2 * (hi + 1));
        exp_pc = {vbyte(slot), vbyte(slot + 16'd1)};
        bytes[0] = pcv[7:0]; bytes[1] = pcv[15:8];
        bytes[2] = xv; bytes[3] = av; bytes[4] = cv;

        @(negedge clk);
        irq_req = pat; imask = 1'b0;
        pc_in = pcv; x_in = xv; a_in = av; ccr_in = cv;
        @(negedge clk);
        chk(!mem_we && !busy, "R3 armed waits", {30'd0, mem_we, busy}, 32'd0);
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
        irq_req = ~pat;
        pc_in = ~pcv; x_in = ~xv; a_in = ~av; ccr_in = ~cv;
        for (int k = 0; k < 5; k++) begin
            if (k > 0) @(negedge clk);
            chk(mem_we && busy && !mem_re, "R4 write strobe", {30'd0, mem_we, busy}, 32'd3);
            chk(mem_addr == exp_sp, "R5 push address", mem_addr, exp_sp);
            chk(mem_wdata == bytes[k], "R4 push data", mem_wdata, bytes[k]);
            exp_sp = exp_sp - 16'd1;
        end
        @(negedge clk);
        chk(imask_set && mem_re && !mem_we, "R6 mask pulse", {31'd0, imask_set}, 32'd1);
        chk(mem_addr == slot, "R7 R8 high slot", mem_addr, slot);
        imask = 1'b1;
        @(negedge clk);
        chk(mem_re && !imask_set && mem_addr == slot + 16'd1, "R8 low slot",
            mem_addr, slot + 16'd1);
        @(negedge clk);
        chk(busy && !mem_re && !done, "R9 capture cycle", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk(done && !busy, "R9 done", {30'd0, done, busy}, 32'd2);
        chk(new_pc == exp_pc, "R9 R10 new pc", new_pc, exp_pc);
        chk(sp == exp_sp, "R5 sp after entry", sp, exp_sp);
        @(negedge clk);
        chk(!done && !busy, "R9 done single", {30'd0, done, busy}, 32'd0);
        irq_req = '0;
        imask = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        exp_sp = SP0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp == SP0, "R1 reset sp", sp, SP0);
        chk(!busy && !done && !mem_we && !mem_re && !imask_set, "R1 reset outputs",
            {27'd0, busy, done, mem_we, mem_re, imask_set}, 32'd0);

        // R2: masked requests with boundary strobes never enter
        irq_req = 8'h90; imask = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            insn_end = ~insn_end;
            chk(!mem_we && !busy, "R2 masked", {30'd0, mem_we, busy}, 32'd0);
        end
        insn_end = 1'b0;
        quiet_window("R2 masked", 10);
        chk(sp == SP0, "R2 sp untouched", sp, SP0);
        irq_req = '0; imask = 1'b0;

        // R11: withdraw while armed
        @(negedge clk);
        irq_req = 8'h04;
        @(negedge clk);
        irq_req = '0;
        @(negedge clk);
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
        quiet_window("R11 withdrawn", 10);

        // R3: pending with no boundary strobe waits
        irq_req = 8'h01;
        quiet_window("R3 no boundary", 8);
        irq_req = '0;
        @(negedge clk);

        // R7 R10: every nonzero request pattern
        for (int p = 1; p < 256; p++) begin
            do_entry(8'(p), 16'(p * 517 + 3), 8'(p ^ 8'h5A), 8'(p * 3), 8'(p + 7));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule